// File: doc/BRIEF.md
# Hybrid Five-Level H-Bridge Modulator

This block drives the eight gates of a single-phase H-bridge made of two three-level T-type legs. Leg A owns switches S1..S4 and leg B owns S5..S8. Each leg can clamp its pole to the positive rail, the midpoint or the negative rail. Together the two legs produce five output levels. The block takes a signed modulation index, the phase of the sine reference, a zero-crossing window width, a mode select and a dead-time count. It compares the duties against a triangular carrier that it generates internally.

In conventional mode both legs switch at the carrier rate in unipolar fashion. Leg B compares against the mirror of leg A's carrier, so the output ripple appears at twice the carrier rate. In hybrid mode, leg B holds a static pole level that depends only on the reference sign, and so switches only at line frequency. Leg A then picks its switch pair and duty from the modulation-index band. Leg A carries all the high-frequency switching, at twice the conventional carrier rate, to keep the ripple equal. When compensation is enabled, any period whose phase lies within the window of a zero crossing falls back to conventional modulation. This suppresses the wrong output pulses that the slow leg would otherwise cause. A latch at the carrier-period boundary captures every reference, mode and polarity decision.

Top module: `hpwm_modulator`

## Requirements
- R1: While reset is held, and on the first cycle after it, `gates` reads 8'b0011_0011. Bit 7 is S1 and bit 0 is S8. Per leg, with the bits in switch order, the midpoint code is 0011, the positive-rail code is 1001 and the negative-rail code is 0110.
- R2: Conventional mode, m >= 0, a = |m| in units of 1/128. Over one 512-cycle period, leg A shows the positive-rail code for 4a cycles and the midpoint code otherwise. Leg B shows the negative-rail code for 4a cycles and the midpoint code otherwise.
- R3: Conventional mode, m < 0. Leg A uses the negative-rail code for 4a of 512 cycles and leg B uses the positive-rail code for 4a of 512 cycles. In both cases the remaining cycles are the midpoint code.
- R4: Hybrid mode holds leg B at the negative-rail code for m >= 0 and at the positive-rail code for m < 0, with no switching inside a period.
- R5: Hybrid mode, a < 64, 256-cycle period. Leg A shows the midpoint code for 4a cycles. For the rest of the period it shows the negative-rail code when m >= 0 and the positive-rail code when m < 0.
- R6: Hybrid mode, a >= 64. Leg A shows, for 2(2a-128) of 256 cycles, the positive-rail code when m >= 0 and the negative-rail code when m < 0. For the rest of the period it shows the midpoint code.
- R7: With hybrid and compensation both selected, conventional modulation is used whenever the phase distance to 0, 512 or 1024 (a 10-bit turn) is below the window value. Hybrid modulation is used otherwise.
- R8: With compensation off, or with a window value of 0, hybrid mode applies at every phase.
- R9: The hybrid carrier period (256 cycles) is half the conventional one (512 cycles).
- R10: Index, polarity, band and mode are latched only at the carrier-period boundary, at the bottom of the triangle. A change mid-period alters gates only from the next period on.
- R11: With a dead time of D cycles, every switch turning off does so at once and every switch turning on is delayed by D cycles. The pairs (S1,S3), (S2,S4), (S5,S7) and (S6,S8) are never on together.
- R12: The index value -128 is taken as magnitude 1.0. It gives a permanent negative-rail code on leg A in both modes, and a permanent positive-rail code on leg B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| modeHybrid | input | 1 | 1 selects hybrid modulation, 0 conventional |
| compEn | input | 1 | Enables conventional fallback near zero crossings |
| modIdx | input | 8 | Signed modulation index, 128 = 1.0 |
| refPhase | input | 10 | Reference phase, 1024 = one turn |
| phaseWindow | input | 9 | Half-width of the zero-crossing window in phase units |
| deadTime | input | 4 | Turn-on delay in clock cycles |
| gates | output | 8 | Gate drives, bit 7 = S1 ... bit 0 = S8 |

## Verification
A corrupted latched band or polarity puts a wrong leg code, or a wrong count of on-cycles, on the gates within one carrier period. A corrupted carrier direction or prescaler shows up as a wrong period length, visible as a changed edge count over a four-period window. A mode or window decision error shows up at the first boundary after the phase is applied: leg B either toggles when it should be static, or stays static when it should switch. A dead-time fault shows as overlapping pair switches, or as missing both-off cycles, on the very next transition.

// File: rtl/hpwm_pkg.sv
`timescale 1ns/1ps
package hpwm_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'd0,
    LVL_POS  = 2'd1,
    LVL_NEG  = 2'd2
  } poleLvl_e;

  typedef struct packed {
    logic loadRef;    // carrier period boundary: latch new reference
    logic hybridNow;  // modulation style in force this period
  } ctrlStrb_t;

  localparam logic [3:0] LEG_SAFE = 4'b0011;

  function automatic logic [3:0] lvlToGates(poleLvl_e lvl);
    case (lvl)
      LVL_POS: lvlToGates = 4'b1001;
      LVL_NEG: lvlToGates = 4'b0110;
      default: lvlToGates = 4'b0011;
    endcase
  endfunction

endpackage

// File: rtl/hpwm_deadband.sv
`timescale 1ns/1ps
module hpwm_deadband import hpwm_pkg::*; #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      target,
  input  logic [DT_W-1:0] deadTime,
  output logic [3:0]      gateOut
);

  logic [3:0]      tgtQ;
  logic [3:0]      outQ;
  logic [DT_W-1:0] holdQ;

  // Turn-offs act at once; turn-ons wait out the hold count.
  always_ff @(posedge clk) begin
    if (rst) begin
      tgtQ  <= LEG_SAFE;
      outQ  <= LEG_SAFE;
      holdQ <= '0;
    end else if (target != tgtQ) begin
      tgtQ  <= target;
      holdQ <= deadTime;
      outQ  <= (deadTime == '0) ? target : (outQ & target);
    end else if (holdQ > 1) begin
      holdQ <= holdQ - 1'b1;
      outQ  <= outQ & target;
    end else begin
      holdQ <= '0;
      outQ  <= target;
    end
  end

  assign gateOut = outQ;

  // R11: complementary switches of a leg never conduct together
  p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
    !(outQ[3] && outQ[1]) && !(outQ[2] && outQ[0]));

  // R11: no switch is turned on in the cycle a new level is requested
  p_on_delayed_r11: assert property (@(posedge clk) disable iff (rst)
    (target != tgtQ && deadTime != '0) |=> ((outQ & ~$past(outQ)) == 4'b0000));

  // R1: reset parks the leg at midpoint
  p_reset_safe_r1: assert property (@(posedge clk)
    $past(rst) |-> (outQ == LEG_SAFE));

endmodule

// File: rtl/hpwm_ctrl.sv
`timescale 1ns/1ps
module hpwm_ctrl import hpwm_pkg::*; #(
  parameter int MOD_W = 8,
  parameter int PH_W  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeHybrid,
  input  logic             compEn,
  input  logic [PH_W-1:0]  refPhase,
  input  logic [PH_W-2:0]  phaseWindow,
  output logic [MOD_W-2:0] carrier,
  output ctrlStrb_t        strb
);

  localparam int CW = MOD_W - 1;
  localparam logic [CW-1:0]   CMAX    = {CW{1'b1}};
  localparam logic [PH_W-1:0] HALF_PH = PH_W'(1) << (PH_W - 1);

  logic [CW-1:0]   cntQ;
  logic            upQ;
  logic            prescQ;
  logic            hybQ;
  logic            tick;
  logic            periodEnd;
  logic            nearCross;
  logic            effHybrid;
  logic [PH_W-1:0] distZero;
  logic [PH_W-1:0] distHalf;

  // Distance of the phase to the nearest zero crossing of the sine.
  always_comb begin
    distZero  = refPhase[PH_W-1] ? (~refPhase + 1'b1) : refPhase;
    distHalf  = refPhase[PH_W-1] ? (refPhase - HALF_PH) : (HALF_PH - refPhase);
    nearCross = ({1'b0, phaseWindow} > distZero) || ({1'b0, phaseWindow} > distHalf);
    effHybrid = modeHybrid && !(compEn && nearCross);
  end

  // Hybrid runs the carrier every clock, conventional every other clock.
  assign tick      = hybQ | prescQ;
  assign periodEnd = tick && !upQ && (cntQ == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ   <= '0;
      upQ    <= 1'b1;
      prescQ <= 1'b0;
      hybQ   <= 1'b0;
    end else begin
      prescQ <= ~prescQ;
      if (tick) begin
        if (upQ) begin
          if (cntQ == CMAX) upQ <= 1'b0;
          else              cntQ <= cntQ + 1'b1;
        end else begin
          if (cntQ == '0)   upQ <= 1'b1;
          else              cntQ <= cntQ - 1'b1;
        end
      end
      if (periodEnd) hybQ <= effHybrid;
    end
  end

  assign carrier = cntQ;

  always_comb begin
    strb.loadRef   = periodEnd;
    strb.hybridNow = hybQ;
  end

  // R10: the modulation style is only updated at the period boundary
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !periodEnd |=> $stable(hybQ));

  // R9: in conventional mode the carrier advances at most every other clock
  p_half_rate_r9: assert property (@(posedge clk) disable iff (rst)
    (!hybQ && tick) |=> (!tick || hybQ));

  // R2: the triangle dwells one step at its peak and reverses
  p_turn_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && upQ && cntQ == CMAX) |=> (!upQ && cntQ == CMAX));

endmodule

// File: rtl/hpwm_datapath.sv
`timescale 1ns/1ps
module hpwm_datapath import hpwm_pkg::*; #(
  parameter int MOD_W = 8,
  parameter int DT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctrlStrb_t               strb,
  input  logic [MOD_W-2:0]        carrier,
  input  logic signed [MOD_W-1:0] modIdx,
  input  logic [DT_W-1:0]         deadTime,
  output logic [7:0]              gates
);

  localparam int FULL = 1 << (MOD_W - 1);
  localparam logic [MOD_W-1:0] FULL_M     = MOD_W'(FULL);
  localparam logic [MOD_W:0]   FULL_W     = (MOD_W + 1)'(FULL);
  localparam logic [MOD_W-1:0] HALF_SCALE = MOD_W'(FULL / 2);
  localparam int NLEG = 2;

  logic [MOD_W-1:0] rawBits;
  logic [MOD_W-1:0] magNext;
  logic [MOD_W:0]   twiceMag;
  logic             upperNext;
  logic [MOD_W:0]   hybWide;

  logic             negQ;
  logic             upperQ;
  logic [MOD_W-1:0] dutyConvQ;
  logic [MOD_W-1:0] dutyHybQ;

  logic [MOD_W-1:0] dutySel;
  logic [MOD_W-1:0] carrierExt;
  logic             legAOn;
  logic             legBOn;
  poleLvl_e         legALvl;
  poleLvl_e         legBLvl;
  logic [3:0]       legTgt [NLEG];

  // Magnitude and band of the incoming index (-full scale maps to 1.0).
  always_comb begin
    rawBits   = modIdx;
    magNext   = rawBits[MOD_W-1] ? (~rawBits + 1'b1) : rawBits;
    twiceMag  = {magNext, 1'b0};
    upperNext = (magNext >= HALF_SCALE);
    hybWide   = upperNext ? (twiceMag - FULL_W) : twiceMag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      negQ      <= 1'b0;
      upperQ    <= 1'b0;
      dutyConvQ <= '0;
      dutyHybQ  <= '0;
    end else if (strb.loadRef) begin
      negQ      <= rawBits[MOD_W-1];
      upperQ    <= upperNext;
      dutyConvQ <= magNext;
      dutyHybQ  <= hybWide[MOD_W-1:0];
    end
  end

  // Leg B compares against the mirrored carrier for unipolar interleave.
  always_comb begin
    carrierExt = {1'b0, carrier};
    dutySel    = strb.hybridNow ? dutyHybQ : dutyConvQ;
    legAOn     = carrierExt < dutySel;
    legBOn     = carrierExt >= (FULL_M - dutyConvQ);
  end

  always_comb begin
    if (strb.hybridNow) begin
      legBLvl = negQ ? LVL_POS : LVL_NEG;
      if (!upperQ) legALvl = legAOn ? LVL_ZERO : (negQ ? LVL_POS : LVL_NEG);
      else         legALvl = legAOn ? (negQ ? LVL_NEG : LVL_POS) : LVL_ZERO;
    end else begin
      legALvl = legAOn ? (negQ ? LVL_NEG : LVL_POS) : LVL_ZERO;
      legBLvl = legBOn ? (negQ ? LVL_POS : LVL_NEG) : LVL_ZERO;
    end
    legTgt[0] = lvlToGates(legALvl);
    legTgt[1] = lvlToGates(legBLvl);
  end

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hpwm_deadband #(.DT_W(DT_W)) u_db (
      .clk      (clk),
      .rst      (rst),
      .target   (legTgt[g]),
      .deadTime (deadTime),
      .gateOut  (gates[7-4*g -: 4])
    );
  end

  // R10: reference state moves only on the boundary strobe
  p_ref_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !strb.loadRef |=> ($stable(dutyConvQ) && $stable(dutyHybQ) &&
                       $stable(negQ) && $stable(upperQ)));

  // R4: in hybrid mode leg B does not switch inside a period
  p_legb_static_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.hybridNow && !strb.loadRef) |=> $stable(legTgt[1]));

endmodule

// File: rtl/hpwm_modulator.sv
`timescale 1ns/1ps
module hpwm_modulator import hpwm_pkg::*; #(
  parameter int MOD_W = 8,
  parameter int PH_W  = 10,
  parameter int DT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    modeHybrid,
  input  logic                    compEn,
  input  logic signed [MOD_W-1:0] modIdx,
  input  logic [PH_W-1:0]         refPhase,
  input  logic [PH_W-2:0]         phaseWindow,
  input  logic [DT_W-1:0]         deadTime,
  output logic [7:0]              gates
);

  ctrlStrb_t        strb;
  logic [MOD_W-2:0] carrier;

  hpwm_ctrl #(.MOD_W(MOD_W), .PH_W(PH_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .modeHybrid  (modeHybrid),
    .compEn      (compEn),
    .refPhase    (refPhase),
    .phaseWindow (phaseWindow),
    .carrier     (carrier),
    .strb        (strb)
  );

  hpwm_datapath #(.MOD_W(MOD_W), .DT_W(DT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .carrier  (carrier),
    .modIdx   (modIdx),
    .deadTime (deadTime),
    .gates    (gates)
  );

endmodule

// File: tb/hpwm_modulator_tb.sv
`timescale 1ns/1ps
module hpwm_modulator_tb;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              modeHybrid = 1'b0;
  logic              compEn = 1'b0;
  logic signed [7:0] modIdx = '0;
  logic [9:0]        refPhase = '0;
  logic [8:0]        phaseWindow = '0;
  logic [3:0]        deadTime = '0;
  logic [7:0]        gates;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  hpwm_modulator u_dut (
    .clk(clk), .rst(rst), .modeHybrid(modeHybrid), .compEn(compEn),
    .modIdx(modIdx), .refPhase(refPhase), .phaseWindow(phaseWindow),
    .deadTime(deadTime), .gates(gates)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  // Leg codes from R1: 0 midpoint, 1 positive rail, 2 negative rail
  function automatic logic [3:0] codeOf(int lvl);
    if (lvl == 1) return 4'b1001;
    if (lvl == 2) return 4'b0110;
    return 4'b0011;
  endfunction

  function automatic bit inWin(int ph, int al);
    int d2;
    d2 = (ph > 512) ? ph - 512 : 512 - ph;
    return (ph < al) || ((1024 - ph) < al) || (d2 < al);
  endfunction

  // Expected high cycles of switch gi (0 = S1) over one period.
  function automatic int expHigh(bit effH, int m, int gi);
    int a, p, len, nA, nB, aOn, aOff, bOn, bOff, n, lOn, lOff, bitPos;
    bit neg;
    logic [3:0] cOn, cOff;
    neg = (m < 0);
    a   = neg ? -m : m;
    p   = effH ? 1 : 2;
    len = 256 * p;
    if (effH) begin
      bOn = neg ? 1 : 2; bOff = bOn; nB = 0;
      if (a < 64) begin aOn = 0; aOff = neg ? 1 : 2; nA = 2 * (2 * a) * p; end
      else begin aOn = neg ? 2 : 1; aOff = 0; nA = 2 * (2 * a - 128) * p; end
    end else begin
      aOn = neg ? 2 : 1; aOff = 0; nA = 2 * a * p;
      bOn = neg ? 1 : 2; bOff = 0; nB = 2 * a * p;
    end
    if (gi < 4) begin n = nA; lOn = aOn; lOff = aOff; bitPos = 3 - gi; end
    else        begin n = nB; lOn = bOn; lOff = bOff; bitPos = 7 - gi; end
    cOn  = codeOf(lOn);
    cOff = codeOf(lOff);
    return n * int'(cOn[bitPos]) + (len - n) * int'(cOff[bitPos]);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setIn(bit hyb, bit comp, int m, int ph, int al, int dt);
    @(negedge clk);
    modeHybrid  = hyb;
    compEn      = comp;
    modIdx      = 8'(m);
    refPhase    = 10'(ph);
    phaseWindow = 9'(al);
    deadTime    = 4'(dt);
  endtask

  task automatic runCase(string req, bit hyb, bit comp, int m, int ph, int al);
    int cnt[8];
    int len, badG, badA, badE;
    bit effH;
    setIn(hyb, comp, m, ph, al, 0);
    repeat (1100) @(negedge clk);
    effH = hyb && !(comp && inWin(ph, al));
    len  = effH ? 256 : 512;
    for (int g = 0; g < 8; g++) cnt[g] = 0;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      for (int g = 0; g < 8; g++) if (gates[7-g]) cnt[g]++;
    end
    badG = -1; badA = 0; badE = 0;
    for (int g = 0; g < 8; g++) begin
      if (badG < 0 && cnt[g] != expHigh(effH, m, g)) begin
        badG = g; badA = cnt[g]; badE = expHigh(effH, m, g);
      end
    end
    check(badG < 0, req, $sformatf("m=%0d hyb=%0d ph=%0d win=%0d S%0d high cycles",
          m, effH, ph, al, badG + 1), badA, badE);
  endtask

  task automatic risingCount(int bitIdx, output int edges);
    logic prev;
    edges = 0;
    @(negedge clk);
    prev = gates[bitIdx];
    for (int c = 0; c < 1024; c++) begin
      @(negedge clk);
      if (gates[bitIdx] && !prev) edges++;
      prev = gates[bitIdx];
    end
  endtask

  initial begin
    int edges, run, s1, s3, bothOff, seedVal;
    logic prev;
    seedVal = $urandom(32'd20240611);

    // R1: reset state
    repeat (4) @(negedge clk);
    check(gates == 8'b0011_0011, "R1", "gates in reset", gates, 8'h33);
    rst = 1'b0;
    @(negedge clk);
    check(gates == 8'b0011_0011, "R1", "gates after release", gates, 8'h33);

    // R2 / R3 conventional
    runCase("R2", 0, 0, 40, 256, 0);
    runCase("R2", 0, 0, 100, 256, 0);
    runCase("R2", 0, 0, 127, 256, 0);
    runCase("R3", 0, 0, -40, 256, 0);
    runCase("R3", 0, 0, -100, 256, 0);
    // R12 full-scale negative
    runCase("R12", 0, 0, -128, 256, 0);
    runCase("R12", 1, 0, -128, 256, 0);
    // R4 leg B polarity
    runCase("R4", 1, 0, 0, 256, 0);
    runCase("R4", 1, 0, -1, 256, 0);
    // R5 low band
    runCase("R5", 1, 0, 20, 256, 0);
    runCase("R5", 1, 0, -30, 256, 0);
    runCase("R5", 1, 0, 63, 256, 0);
    // R6 high band
    runCase("R6", 1, 0, 64, 256, 0);
    runCase("R6", 1, 0, 100, 256, 0);
    runCase("R6", 1, 0, -64, 256, 0);
    runCase("R6", 1, 0, -110, 256, 0);
    runCase("R6", 1, 0, 127, 256, 0);
    // R7 zero-crossing fallback
    runCase("R7", 1, 1, 30, 10, 20);
    runCase("R7", 1, 1, -30, 1015, 20);
    runCase("R7", 1, 1, 30, 500, 20);
    runCase("R7", 1, 1, 30, 200, 20);
    // R8 fallback disabled
    runCase("R8", 1, 0, 30, 10, 20);
    runCase("R8", 1, 1, 30, 0, 0);

    // R9: hybrid period half the conventional one
    setIn(1, 0, 20, 256, 0, 0);
    repeat (1100) @(negedge clk);
    risingCount(4, edges);
    check(edges == 4, "R9", "S4 rising edges in 1024 cycles (hybrid)", edges, 4);
    setIn(0, 0, 20, 256, 0, 0);
    repeat (1100) @(negedge clk);
    risingCount(7, edges);
    check(edges == 2, "R9", "S1 rising edges in 1024 cycles (conventional)", edges, 2);

    // R10: index change inside a pulse only acts after the boundary
    setIn(1, 0, 20, 256, 0, 0);
    repeat (1100) @(negedge clk);
    prev = gates[4];
    run = 0;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      if (gates[4] && !prev) begin
        modIdx = 8'sd10;
        run = 1;
        break;
      end
      prev = gates[4];
    end
    for (int c = 0; c < 400 && run > 0; c++) begin
      @(negedge clk);
      if (gates[4]) run++;
      else break;
    end
    check(run == 60, "R10", "S4 pulse spanning the index change", run, 60);

    // R11: dead time on conventional leg A
    setIn(0, 0, 64, 256, 0, 3);
    repeat (1100) @(negedge clk);
    s1 = 0; s3 = 0; bothOff = 0;
    for (int c = 0; c < 512; c++) begin
      @(negedge clk);
      if (gates[7]) s1++;
      if (gates[5]) s3++;
      if (!gates[7] && !gates[5]) bothOff++;
    end
    check(s1 == 253, "R11", "S1 high with dead time 3", s1, 253);
    check(s3 == 253, "R11", "S3 high with dead time 3", s3, 253);
    check(bothOff == 6, "R11", "S1/S3 both-off cycles", bothOff, 6);

    // Random mix across modes and windows (R7 selection, R2-R6 shapes)
    for (int i = 0; i < 16; i++) begin
      int m, ph, al;
      bit hyb, comp;
      m    = int'($urandom % 256) - 128;
      ph   = int'($urandom % 1024);
      al   = int'($urandom % 64);
      hyb  = 1'($urandom);
      comp = 1'($urandom);
      runCase("R7", hyb, comp, m, ph, al);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule